// File: doc/BRIEF.md
# Two-Function Bridge Configuration Register File

This block holds the byte-wide configuration space of a chipset device that shows two functions: function 0 is a host bridge and function 1 is a PCI-to-PCI bridge. Each function has 256 bytes of storage. A configuration cycle carries a 3-bit function number, an 8-bit register address and, on writes, one data byte. Writes go through a per-function rule map before they land. Some addresses cannot be written at all. Some command bits are locked. Status bits clear when a 1 is written to them. Window base and limit bytes always keep their lower nibble at zero.

Reads are combinational. While the read strobe is high, the stored byte of the addressed function appears on the read-data port in that same cycle. The three function-0 shadow-control bytes (0x61, 0x62 and 0x63) also drive dedicated parallel outputs, so that memory-decode logic elsewhere can follow them. A single-cycle update flag tells that logic when any of the three bytes has changed. Strobes are plain level inputs sampled on the rising clock edge. The block accepts one access every cycle and never pushes back, so there is no ready signal.

Top module: `bridge_cfg_regfile`

## Requirements
- R1: After reset, every byte of both functions reads 0x00, with three exceptions. Byte 0x07 of function 0 reads parameter F0_STAT_INIT (default 0xB2). Byte 0x07 of function 1 reads F1_STAT_INIT (default 0x32). Byte 0x63 of function 0 reads SHADOW3_INIT with bits 5:4 forced to 0, which is 0xCF for the default 0xFF.
- R2: A write to a function number of 2 or higher changes no stored byte. A read of such a function returns 0xFF.
- R3: In function 0, writes do nothing at these addresses: 0x00-0x03, 0x05-0x06, 0x08-0x0C, 0x0E-0x11, 0x14-0x4F, 0x79-0x7D, 0x85-0x87, 0x8C-0xA7 and 0xAD-0xFC.
- R4: In function 1, writes do nothing at these addresses: 0x00-0x03, 0x05-0x06, 0x08-0x17, 0x1B, 0x1E-0x1F, 0x28-0x3D, and every address from 0x43 to 0xFF.
- R5: Byte 0x04 is the command byte. In function 0 only bit 6 takes the written value. In function 1 only bits 6, 2, 1 and 0 take the written value. All other bits keep their old value.
- R6: Byte 0x07 is the status byte. A written 1 clears bits 7, 5 and 4 in function 0, and bits 5 and 4 in function 1. Written zeros and all other bits leave the byte unchanged.
- R7: In function 0, byte 0x12 stores the upper nibble of the written value and a zero lower nibble. Byte 0x13 stores the full written byte.
- R8: In function 1, bytes 0x20, 0x22, 0x24 and 0x26 store the upper nibble of the written value and a zero lower nibble.
- R9: Every other address stores the full written byte, and a read sees the new value from the cycle after the write edge. While rd_en is low, rd_data is 0x00.
- R10: Outputs shadow_c, shadow_d and shadow_ef always equal function-0 bytes 0x61, 0x62 and 0x63.
- R11: shadow_upd is high for exactly the one cycle after a clock edge that changed any of those three bytes. It stays low when a write leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_fn | input | FN_W | Function number of the access |
| acc_addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid in the cycle rd_en is high |
| shadow_c | output | 8 | Function-0 byte 0x61 |
| shadow_d | output | 8 | Function-0 byte 0x62 |
| shadow_ef | output | 8 | Function-0 byte 0x63 |
| shadow_upd | output | 1 | One-cycle flag after a shadow byte changes |

## Verification
Every address of both functions is written with five data patterns in turn: 0x5A, 0xFF, 0x00, 0xA5 and 0x3C, and each write is followed by a read-back. Complementary patterns separate bits that are locked from bits that take data, and separate a low nibble that is forced to zero from one that stores. Writing 0xFF first and then 0x00 shows that status bits only clear and never set again. Writes to unused function numbers are followed by reads of the same address in both real functions, and a 0x61 write that repeats the stored value shows the update flag stays low.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 8;
  typedef logic [CFG_DW-1:0] cfg_byte_t;
  typedef logic [CFG_AW-1:0] cfg_addr_t;

  // host-bridge write-protected addresses
  function automatic logic hb_locked(input cfg_addr_t a);
    return (a <= 8'h03) || (a inside {[8'h05:8'h06]}) ||
           (a inside {[8'h08:8'h0C]}) || (a inside {[8'h0E:8'h11]}) ||
           (a inside {[8'h14:8'h4F]}) || (a inside {[8'h79:8'h7D]}) ||
           (a inside {[8'h85:8'h87]}) || (a inside {[8'h8C:8'hA7]}) ||
           (a inside {[8'hAD:8'hFC]});
  endfunction

  // bridge-to-bridge write-protected addresses
  function automatic logic pb_locked(input cfg_addr_t a);
    return (a <= 8'h03) || (a inside {[8'h05:8'h06]}) ||
           (a inside {[8'h08:8'h17]}) || (a == 8'h1B) ||
           (a inside {[8'h1E:8'h1F]}) || (a inside {[8'h28:8'h3D]}) ||
           (a >= 8'h43);
  endfunction
endpackage

// File: rtl/cfg_write_rule.sv
module cfg_write_rule
  import cfg_pkg::*;
#(
  parameter int FN_IDX = 0
) (
  input  cfg_addr_t addr,
  input  cfg_byte_t old_val,
  input  cfg_byte_t new_val,
  output logic      locked,
  output cfg_byte_t merged
);
  localparam cfg_byte_t CMD_MASK  = (FN_IDX == 0) ? 8'h40 : 8'h47;
  localparam cfg_byte_t STAT_MASK = (FN_IDX == 0) ? 8'hB0 : 8'h30;

  logic nib_forced;

  generate
    if (FN_IDX == 0) begin : g_host
      assign locked     = hb_locked(addr);
      assign nib_forced = (addr == 8'h12);
    end else begin : g_p2p
      assign locked     = pb_locked(addr);
      assign nib_forced = (addr == 8'h20) || (addr == 8'h22) ||
                          (addr == 8'h24) || (addr == 8'h26);
    end
  endgenerate

  always_comb begin
    if (addr == 8'h04)
      merged = (old_val & ~CMD_MASK) | (new_val & CMD_MASK);
    else if (addr == 8'h07)
      merged = old_val & ~(new_val & STAT_MASK);
    else if (nib_forced)
      merged = {new_val[7:4], 4'h0};
    else
      merged = new_val;
  end
endmodule

// File: rtl/cfg_fn_bank.sv
module cfg_fn_bank
  import cfg_pkg::*;
#(
  parameter int        FN_IDX       = 0,
  parameter cfg_byte_t STAT_INIT    = 8'h00,
  parameter cfg_byte_t SHADOW3_INIT = 8'hFF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  cfg_addr_t addr,
  input  cfg_byte_t wdata,
  output cfg_byte_t rdata,
  output cfg_byte_t tap_c,
  output cfg_byte_t tap_d,
  output cfg_byte_t tap_ef
);
  localparam int DEPTH = 1 << CFG_AW;

  cfg_byte_t mem [DEPTH];
  cfg_byte_t nxt;
  logic      locked;

  function automatic cfg_byte_t init_of(input int idx);
    if (idx == 7) return STAT_INIT;
    if (FN_IDX == 0 && idx == 'h63) return SHADOW3_INIT & 8'hCF;
    return 8'h00;
  endfunction

  assign rdata  = mem[addr];
  assign tap_c  = mem[8'h61];
  assign tap_d  = mem[8'h62];
  assign tap_ef = mem[8'h63];

  cfg_write_rule #(.FN_IDX(FN_IDX)) u_rule (
    .addr   (addr),
    .old_val(mem[addr]),
    .new_val(wdata),
    .locked (locked),
    .merged (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_of(i);
    end else if (we && !locked) begin
      mem[addr] <= nxt;
    end
  end

  // status byte can only lose bits
  AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[7] & ~$past(mem[7])) == 8'h00); // R6

  generate
    if (FN_IDX == 0) begin : g_chk_host
      AST_HOST_CMD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[4] & 8'hBF) == 8'h00); // R5
      AST_APERTURE_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        mem[8'h12][3:0] == 4'h0); // R7
    end else begin : g_chk_p2p
      AST_P2P_CMD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[4] & 8'hB8) == 8'h00); // R5
      AST_WINDOW_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[8'h20][3:0] | mem[8'h22][3:0] | mem[8'h24][3:0] | mem[8'h26][3:0]) == 4'h0); // R8
    end
  endgenerate
endmodule

// File: rtl/bridge_cfg_regfile.sv
module bridge_cfg_regfile
  import cfg_pkg::*;
#(
  parameter int        FN_W         = 3,
  parameter cfg_byte_t F0_STAT_INIT = 8'hB2,
  parameter cfg_byte_t F1_STAT_INIT = 8'h32,
  parameter cfg_byte_t SHADOW3_INIT = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FN_W-1:0] acc_fn,
  input  logic [7:0]      acc_addr,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  output logic [7:0]      rd_data,
  output logic [7:0]      shadow_c,
  output logic [7:0]      shadow_d,
  output logic [7:0]      shadow_ef,
  output logic            shadow_upd
);
  localparam int NUM_FN = 2;
  localparam int SH_W   = 3 * CFG_DW;

  cfg_byte_t bank_rd [NUM_FN];
  cfg_byte_t tap_c   [NUM_FN];
  cfg_byte_t tap_d   [NUM_FN];
  cfg_byte_t tap_ef  [NUM_FN];
  logic [SH_W-1:0] sh_now, sh_prev;
  logic fn_known;

  assign fn_known = (acc_fn < FN_W'(NUM_FN));

  generate
    for (genvar g = 0; g < NUM_FN; g++) begin : g_bank
      cfg_fn_bank #(
        .FN_IDX      (g),
        .STAT_INIT   ((g == 0) ? F0_STAT_INIT : F1_STAT_INIT),
        .SHADOW3_INIT(SHADOW3_INIT)
      ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && (acc_fn == FN_W'(g))),
        .addr  (acc_addr),
        .wdata (wr_data),
        .rdata (bank_rd[g]),
        .tap_c (tap_c[g]),
        .tap_d (tap_d[g]),
        .tap_ef(tap_ef[g])
      );
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) rd_data = fn_known ? bank_rd[acc_fn[0]] : 8'hFF;
  end

  assign shadow_c  = tap_c[0];
  assign shadow_d  = tap_d[0];
  assign shadow_ef = tap_ef[0];
  assign sh_now    = {tap_c[0], tap_d[0], tap_ef[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) sh_prev <= {SH_W{1'b0}};
    else        sh_prev <= sh_now;
  end

  // the cycle right after reset compares against a cleared copy, so mask it
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign shadow_upd = armed && (sh_now != sh_prev);

  AST_ALIEN_FN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fn_known) |-> rd_data == 8'hFF); // R2
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 8'h00); // R9
  AST_UPD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_upd |-> ($past(wr_en) && $past(acc_fn) == '0)); // R11
  AST_UPD_NO_F0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(wr_en && acc_fn == '0)) |-> !shadow_upd); // R11
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_upd |-> $stable(shadow_ef)); // R10
endmodule

// File: tb/bridge_cfg_regfile_bench.sv
module bridge_cfg_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] acc_fn = '0;
  logic [7:0] acc_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data, shadow_c, shadow_d, shadow_ef;
  logic       shadow_upd;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [2][256];
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_cfg_regfile u_bridge_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .acc_fn(acc_fn), .acc_addr(acc_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .shadow_c(shadow_c), .shadow_d(shadow_d), .shadow_ef(shadow_ef),
    .shadow_upd(shadow_upd)
  );

  function automatic logic locked(input int f, input int a);
    if (f == 0)
      return a < 4 || (a >= 5 && a < 7) || (a >= 8 && a < 13) || (a >= 14 && a < 18) ||
             (a >= 20 && a < 80) || (a >= 121 && a < 126) || (a >= 133 && a < 136) ||
             (a >= 140 && a < 168) || (a >= 173 && a < 253);
    return a < 4 || (a >= 5 && a < 7) || (a >= 8 && a < 24) || a == 27 ||
           (a >= 30 && a < 32) || (a >= 40 && a < 62) || a >= 67;
  endfunction

  function automatic logic [7:0] model(input int f, input int a, input logic [7:0] o, input logic [7:0] v);
    if (locked(f, a)) return o;
    if (a == 4) return (f == 0) ? ((o & 8'hBF) | (v & 8'h40)) : ((o & 8'hB8) | (v & 8'h47));
    if (a == 7) return (f == 0) ? (o & ~(v & 8'hB0)) : (o & ~(v & 8'h30));
    if (f == 0 && a == 18) return v & 8'hF0;
    if (f == 1 && (a == 32 || a == 34 || a == 36 || a == 38)) return v & 8'hF0;
    return v;
  endfunction

  function automatic string tag(input int f, input int a);
    if (locked(f, a)) return (f == 0) ? "R3" : "R4";
    if (a == 4) return "R5";
    if (a == 7) return "R6";
    if (f == 0 && (a == 18 || a == 19)) return "R7";
    if (f == 1 && (a == 32 || a == 34 || a == 36 || a == 38)) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic rd_chk(input int f, input int a, input logic [7:0] expv, input string req);
    @(negedge clk);
    acc_fn = 3'(f); acc_addr = 8'(a); rd_en = 1'b1;
    #1 check(req, rd_data, expv);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_do(input int f, input int a, input logic [7:0] v);
    logic [7:0] sh_old;
    logic [7:0] sh_new;
    logic upd_exp;
    sh_old = (a >= 97 && a <= 99 && f == 0) ? exp_mem[0][a] : 8'h00;
    @(negedge clk);
    acc_fn = 3'(f); acc_addr = 8'(a); wr_data = v; wr_en = 1'b1;
    if (f < 2) exp_mem[f][a] = model(f, a, exp_mem[f][a], v);
    sh_new = (a >= 97 && a <= 99 && f == 0) ? exp_mem[0][a] : 8'h00;
    upd_exp = (sh_new != sh_old);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R11", {7'd0, shadow_upd}, {7'd0, upd_exp});
    check("R10", shadow_c, exp_mem[0][97]);
    check("R10", shadow_d, exp_mem[0][98]);
    check("R10", shadow_ef, exp_mem[0][99]);
    @(negedge clk);
    #1 check("R11", {7'd0, shadow_upd}, 8'h00);
  endtask

  initial begin
    logic [7:0] pats [5];
    pats = '{8'h5A, 8'hFF, 8'h00, 8'hA5, 8'h3C};
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 256; a++) exp_mem[f][a] = 8'h00;
    exp_mem[0][7] = 8'hB2; exp_mem[1][7] = 8'h32; exp_mem[0][99] = 8'hCF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset image
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 256; a++) rd_chk(f, a, exp_mem[f][a], "R1");
    // R2 unused functions read all ones
    for (int f = 2; f < 8; f++) rd_chk(f, 8'h40 + f, 8'hFF, "R2");
    // R9 idle read port
    @(negedge clk); acc_fn = 0; acc_addr = 8'h07; rd_en = 1'b0;
    #1 check("R9", rd_data, 8'h00);
    // sweep
    for (int p = 0; p < 5; p++)
      for (int f = 0; f < 2; f++)
        for (int a = 0; a < 256; a++) begin
          wr_do(f, a, pats[p]);
          rd_chk(f, a, exp_mem[f][a], tag(f, a));
        end
    // R2 writes to unused functions land nowhere
    for (int f = 2; f < 8; f++) begin
      wr_do(f, 8'h61, 8'h11 * f);
      wr_do(f, 8'h50, 8'h0F);
      rd_chk(0, 8'h61, exp_mem[0][97], "R2");
      rd_chk(1, 8'h50, exp_mem[1][80], "R2");
      rd_chk(0, 8'h50, exp_mem[0][80], "R2");
    end
    // R11 repeating the stored value raises no flag
    wr_do(0, 8'h61, 8'h77);
    wr_do(0, 8'h61, 8'h77);
    rd_chk(0, 8'h61, 8'h77, "R11");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule